// File: doc/BRIEF.md
# Watermark Receive FIFO

This block is the receive buffer between a serial shift engine and a register-read port. The shift engine delivers one byte per accepted beat. The block packs these bytes into 32-bit storage words, with the earliest byte in the lowest lane. When a whole window of unread bytes has gathered, a registered flag rises. The size of that window is the watermark, eight bytes by default. Software then reads the window as a small set of consecutive words, picked by a word select input.

Software does not pop words one at a time. It releases the whole window by writing one to the flag (a pulse on `wm_ack`). This clears the flag and moves the read pointer on by one watermark. A clear command empties the FIFO and returns both pointers to zero. The unread byte count is always visible. Software uses it to fetch a trailing remainder that never reaches the watermark. When the FIFO is full, the block withholds `in_ready` so the shift engine stalls, and no stored byte is overwritten.

Top module: `rxwm_fifo`

## Requirements
- R1: Bytes are packed little-endian: the first byte of a storage word sits in bits [7:0], the next in [15:8], and so on. Lanes of the word currently being filled that have not yet been written read as zero.
- R2: `wm_flag` rises on the clock edge after the one at which the unread byte count first reaches WM_BYTES (8). It never stays high while fewer than WM_BYTES bytes are unread.
- R3: With `win_sel` = 0, `win_word` returns the word at the read pointer. With `win_sel` = 1, it returns the next word. The output is combinational from the pointer.
- R4: A `wm_ack` pulse while `wm_flag` is high clears the flag and reduces the unread count by exactly WM_BYTES. A byte accepted in the same cycle still counts.
- R5: A `wm_ack` pulse while `wm_flag` is low has no effect on the count, the flag or the window contents.
- R6: If at least WM_BYTES bytes are unread and no release takes place, the flag stays set as more data arrives. After a release that leaves WM_BYTES or more unread, the flag rises again one cycle later.
- R7: `fifo_clr` sets the count to zero and clears the flag at the next edge, and both pointers restart at storage word 0. In the same cycle it overrides both a byte write and a `wm_ack`. A `wm_ack` after a clear therefore moves nothing.
- R8: `fill_bytes` equals the number of bytes accepted and not yet released. A part-window remainder is readable through the window.
- R9: `in_ready` is low exactly when DEPTH_BYTES (128) bytes are unread. A byte offered while `in_ready` is low is neither stored nor counted.
- R10: After reset the count is 0, `wm_flag` is low and `in_ready` is high.
- R11: Data that wraps past the end of storage reads back in arrival order through successive windows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_byte | input | 8 | Byte from the shift engine |
| in_valid | input | 1 | `in_byte` is offered this cycle |
| in_ready | output | 1 | A byte can be accepted this cycle |
| win_sel | input | SEL_W (1) | Word select inside the current window |
| win_word | output | 32 | Selected window word |
| wm_flag | output | 1 | A full watermark window is waiting |
| wm_ack | input | 1 | Write-one-to-clear of `wm_flag`, which releases the window |
| fifo_clr | input | 1 | Discard all data and reset both pointers |
| fill_bytes | output | PTR_W (8) | Unread byte count |

## Verification
A table of pushes, releases, drains and clears drives the block, and a byte-level model in the bench checks the count, the flag and both window words after every step. Pushes of odd lengths (3, 5, 11 bytes) leave partly filled words, which exposes lane placement and the zero fill of unwritten lanes. Releases with a remainder of fewer or more than eight bytes tell the one-shot clear apart from the re-assertion of the flag. Releases with the flag low show that they are ignored. A fill to 128 bytes followed by more offers separates a stall from an overwrite. Draining after that run reads data that has wrapped in storage, and directed same-cycle collisions of clear, write and release settle their precedence.

// File: rtl/rxwm_pkg.sv
package rxwm_pkg;

  // Position a byte in its storage lane; other lanes zero.
  function automatic logic [31:0] lane_place(input logic [7:0] b, input logic [1:0] lane);
    return {24'b0, b} << (8 * lane);
  endfunction

  // Lane 0 starts a fresh word, so it writes all lanes to clear stale bytes.
  function automatic logic [3:0] lane_mask(input logic [1:0] lane);
    return (lane == 2'd0) ? 4'hF : (4'b0001 << lane);
  endfunction

endpackage

// File: rtl/rxwm_wr_side.sv
module rxwm_wr_side #(
  parameter int DEPTH_BYTES = 128,
  parameter int PTR_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             in_valid,
  input  logic [PTR_W-1:0] fill,
  output logic             in_ready,
  output logic             push,
  output logic [PTR_W-1:0] wr_ptr
);
  localparam logic [PTR_W-1:0] FULL_CNT = PTR_W'(DEPTH_BYTES);

  logic [PTR_W-1:0] wr_ptr_q;

  assign in_ready = (fill != FULL_CNT);
  assign push     = in_valid & in_ready & ~clr;
  assign wr_ptr   = wr_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    wr_ptr_q <= '0;
    else if (clr)  wr_ptr_q <= '0;
    else if (push) wr_ptr_q <= wr_ptr_q + 1'b1;
  end
endmodule

// File: rtl/rxwm_store.sv
module rxwm_store #(
  parameter int DEPTH_WORDS = 32,
  parameter int AW          = 5
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [3:0]    wbe,
  input  logic [31:0]   wdata,
  input  logic [AW-1:0] raddr,
  output logic [31:0]   rdata
);
  logic [31:0] mem [DEPTH_WORDS];

  always_ff @(posedge clk) begin
    for (int l = 0; l < 4; l++) begin
      if (we && wbe[l]) mem[waddr][8*l +: 8] <= wdata[8*l +: 8];
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rxwm_rd_side.sv
module rxwm_rd_side #(
  parameter int WM_BYTES = 8,
  parameter int PTR_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ack,
  input  logic [PTR_W-1:0] fill,
  output logic             flag,
  output logic             advance,
  output logic [PTR_W-1:0] rd_ptr
);
  localparam logic [PTR_W-1:0] WM_CNT = PTR_W'(WM_BYTES);

  logic [PTR_W-1:0] rd_ptr_q;
  logic             flag_q;

  assign advance = ack & flag_q & ~clr;
  assign flag    = flag_q;
  assign rd_ptr  = rd_ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_ptr_q <= '0;
    else if (clr)     rd_ptr_q <= '0;
    else if (advance) rd_ptr_q <= rd_ptr_q + WM_CNT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               flag_q <= 1'b0;
    else if (clr || advance)  flag_q <= 1'b0;
    else if (fill >= WM_CNT)  flag_q <= 1'b1;
  end
endmodule

// File: rtl/rxwm_fifo.sv
module rxwm_fifo #(
  parameter int DEPTH_BYTES = 128,
  parameter int WM_BYTES    = 8,
  localparam int WM_WORDS   = WM_BYTES / 4,
  localparam int SEL_W      = (WM_WORDS > 1) ? $clog2(WM_WORDS) : 1,
  localparam int PTR_W      = $clog2(DEPTH_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       in_byte,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SEL_W-1:0] win_sel,
  output logic [31:0]      win_word,
  output logic             wm_flag,
  input  logic             wm_ack,
  input  logic             fifo_clr,
  output logic [PTR_W-1:0] fill_bytes
);
  import rxwm_pkg::*;

  localparam int DEPTH_WORDS = DEPTH_BYTES / 4;
  localparam int AW          = $clog2(DEPTH_WORDS);

  logic [PTR_W-1:0] wr_ptr, rd_ptr, fill;
  logic             push, advance;
  logic [AW-1:0]    waddr, raddr;
  logic [1:0]       lane;

  assign fill       = wr_ptr - rd_ptr;
  assign fill_bytes = fill;
  assign lane       = wr_ptr[1:0];
  assign waddr      = wr_ptr[AW+1:2];
  assign raddr      = rd_ptr[AW+1:2] + AW'(win_sel);

  rxwm_wr_side #(.DEPTH_BYTES(DEPTH_BYTES), .PTR_W(PTR_W)) wr_i (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .in_valid(in_valid),
    .fill(fill), .in_ready(in_ready), .push(push), .wr_ptr(wr_ptr));

  rxwm_rd_side #(.WM_BYTES(WM_BYTES), .PTR_W(PTR_W)) rd_i (
    .clk(clk), .rst_n(rst_n), .clr(fifo_clr), .ack(wm_ack), .fill(fill),
    .flag(wm_flag), .advance(advance), .rd_ptr(rd_ptr));

  rxwm_store #(.DEPTH_WORDS(DEPTH_WORDS), .AW(AW)) mem_i (
    .clk(clk), .we(push), .waddr(waddr), .wbe(lane_mask(lane)),
    .wdata(lane_place(in_byte, lane)), .raddr(raddr), .rdata(win_word));
endmodule

// File: rtl/rxwm_fifo_chk.sv
module rxwm_fifo_chk #(
  parameter int DEPTH_BYTES = 128,
  parameter int WM_BYTES    = 8,
  parameter int PTR_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wm_ack,
  input logic             fifo_clr,
  input logic             wm_flag,
  input logic [PTR_W-1:0] fill_bytes,
  input logic             push,
  input logic             advance
);
  // R9
  fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_bytes) <= DEPTH_BYTES);

  // R9
  full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_bytes) == DEPTH_BYTES && !advance && !fifo_clr) |=> int'(fill_bytes) == DEPTH_BYTES);

  // R7
  clr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> (fill_bytes == '0 && !wm_flag));

  // R2
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_bytes) >= WM_BYTES && !fifo_clr && !(wm_ack && wm_flag)) |=> wm_flag);

  // R2
  flag_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wm_flag |-> int'(fill_bytes) >= WM_BYTES);

  // R4
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_ack && wm_flag && !fifo_clr) |=>
      (!wm_flag && int'(fill_bytes) == int'($past(fill_bytes)) - WM_BYTES + int'($past(push))));

  // R5
  idle_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wm_ack && !wm_flag && !fifo_clr) |=>
      int'(fill_bytes) == int'($past(fill_bytes)) + int'($past(push)));
endmodule

bind rxwm_fifo rxwm_fifo_chk #(.DEPTH_BYTES(DEPTH_BYTES), .WM_BYTES(WM_BYTES), .PTR_W(PTR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wm_ack(wm_ack), .fifo_clr(fifo_clr), .wm_flag(wm_flag),
  .fill_bytes(fill_bytes), .push(push), .advance(advance));

// File: tb/rxwm_fifo_tb_top.sv
`timescale 1ns/1ps
module rxwm_fifo_tb_top;
  localparam int CLK_HALF = 10;
  localparam int WM = 8;
  localparam int DEPTH = 128;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] in_byte = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [0:0] win_sel = '0;
  logic [31:0] win_word;
  logic       wm_flag;
  logic       wm_ack = 1'b0;
  logic       fifo_clr = 1'b0;
  logic [7:0] fill_bytes;

  always #CLK_HALF clk = ~clk;

  rxwm_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_valid(in_valid), .in_ready(in_ready),
    .win_sel(win_sel), .win_word(win_word), .wm_flag(wm_flag), .wm_ack(wm_ack),
    .fifo_clr(fifo_clr), .fill_bytes(fill_bytes));

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] model [1024];
  int model_wr = 0;
  int model_rd = 0;
  int seed = 0;

  // op: 0 push arg bytes, 1 release, 2 clear, 3 drain (R11)
  localparam int NSTEP = 18;
  localparam logic [18:0] STEPS [NSTEP] = '{
    {2'd0, 8'd3,   8'd3,   1'b0},
    {2'd0, 8'd4,   8'd7,   1'b0},
    {2'd1, 8'd0,   8'd7,   1'b0},
    {2'd0, 8'd1,   8'd8,   1'b1},
    {2'd0, 8'd5,   8'd13,  1'b1},
    {2'd1, 8'd0,   8'd5,   1'b0},
    {2'd0, 8'd11,  8'd16,  1'b1},
    {2'd1, 8'd0,   8'd8,   1'b1},
    {2'd1, 8'd0,   8'd0,   1'b0},
    {2'd0, 8'd100, 8'd100, 1'b1},
    {2'd1, 8'd0,   8'd92,  1'b1},
    {2'd0, 8'd30,  8'd122, 1'b1},
    {2'd0, 8'd6,   8'd128, 1'b1},
    {2'd0, 8'd3,   8'd128, 1'b1},
    {2'd1, 8'd0,   8'd120, 1'b1},
    {2'd3, 8'd0,   8'd0,   1'b0},
    {2'd2, 8'd0,   8'd0,   1'b0},
    {2'd0, 8'd2,   8'd2,   1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    return (i < model_wr) ? model[i % 1024] : 8'h00;
  endfunction

  task automatic check_window(input string req);
    for (int s = 0; s < 2; s++) begin
      int base = model_rd + 4 * s;
      if (base < model_wr) begin
        win_sel = 1'(s);
        #1;
        chk(req, int'(win_word),
            int'({exp_byte(base + 3), exp_byte(base + 2), exp_byte(base + 1), exp_byte(base)}));
      end
    end
    win_sel = '0;
  endtask

  task automatic do_push(input int n);
    for (int k = 0; k < n; k++) begin
      in_byte  = 8'(seed * 37 + 11);
      seed++;
      in_valid = 1'b1;
      if (in_ready) begin
        model[model_wr % 1024] = in_byte;
        model_wr++;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_ack();
    wm_ack = 1'b1;
    if (wm_flag) model_rd += WM;
    @(negedge clk);
    wm_ack = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_clr();
    fifo_clr = 1'b1;
    model_wr = 0;
    model_rd = 0;
    @(negedge clk);
    fifo_clr = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(2 * CLK_HALF * 200000);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk("R10 fill", int'(fill_bytes), 0);
    chk("R10 flag", int'(wm_flag), 0);
    chk("R10 ready", int'(in_ready), 1);

    for (int i = 0; i < NSTEP; i++) begin
      logic [1:0] op;
      logic [7:0] arg, efill;
      logic       eflag;
      {op, arg, efill, eflag} = STEPS[i];
      case (op)
        2'd0: do_push(int'(arg));
        2'd1: do_ack();
        2'd2: do_clr();
        default: begin
          while (wm_flag) begin
            do_ack();
            check_window("R11 wrapped window");
          end
        end
      endcase
      // R8 count, R2/R6 flag, R1/R3 window, R9 at full step
      chk($sformatf("R8 fill step %0d", i), int'(fill_bytes), int'(efill));
      chk($sformatf("R6 flag step %0d", i), int'(wm_flag), int'(eflag));
      chk($sformatf("R9 ready step %0d", i), int'(in_ready), (int'(efill) == DEPTH) ? 0 : 1);
      check_window($sformatf("R3 window step %0d", i));
    end

    // R1 two-byte word: upper lanes read zero
    win_sel = '0;
    #1;
    chk("R1 lane zero", int'(win_word[31:16]), 0);

    // R7 clear wins over a write in the same cycle
    fifo_clr = 1'b1;
    in_valid = 1'b1;
    in_byte  = 8'hA5;
    model_wr = 0;
    model_rd = 0;
    @(negedge clk);
    fifo_clr = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R7 clr beats write", int'(fill_bytes), 0);

    // R4 release with a write in the same cycle
    do_push(8);
    chk("R2 flag at 8", int'(wm_flag), 1);
    wm_ack   = 1'b1;
    in_valid = 1'b1;
    in_byte  = 8'h5C;
    model[model_wr % 1024] = 8'h5C;
    model_wr++;
    model_rd += WM;
    @(negedge clk);
    wm_ack   = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    chk("R4 release with write fill", int'(fill_bytes), 1);
    chk("R4 release flag", int'(wm_flag), 0);
    check_window("R4 window after release");

    // R7 clear beats a release, then a release after clear does nothing
    do_push(7);
    chk("R2 flag before clr", int'(wm_flag), 1);
    wm_ack   = 1'b1;
    fifo_clr = 1'b1;
    model_wr = 0;
    model_rd = 0;
    @(negedge clk);
    wm_ack   = 1'b0;
    fifo_clr = 1'b0;
    @(negedge clk);
    chk("R7 clr beats release fill", int'(fill_bytes), 0);
    chk("R7 clr beats release flag", int'(wm_flag), 0);
    do_push(3);
    do_ack();
    chk("R5 release after clr fill", int'(fill_bytes), 3);
    check_window("R7 pointers restart");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule